// File: doc/BRIEF.md
# Serial ADC Control-Word Front End

This block is the digital control side of a multichannel successive-approximation converter. A host sends an 8-bit command one bit per serial clock while chip select is low. The block hunts for a start bit, collects the channel number and input mode, and drives the track and hold controls at fixed serial-clock edges. It also drives the positive and negative input-select codes for the analog multiplexer. Once hold begins, it runs a 10-step binary search against an external comparator and reports the result.

The serial pins are sampled by a faster system clock, and serial edges are found by comparing successive samples. Differential inputs are limited to adjacent even/odd channel pairs, and one channel bit picks the polarity. When a conversion ends, the sampling node goes back to the positive input and tracking resumes with the same selection.

Top module: `sadc_ctrl_fe`

## Requirements
- R1: After reset, track_o, hold_o and done_o are 0, result_o is 0, pos_ch_o and neg_ch_o are 0, and neg_com_o is 1.
- R2: Data is taken on rising sclk_i edges while cs_ni is 0, MSB first. A 0 seen while no word is in progress is skipped, and a word begins with the first 1, which is command bit 7 (the start bit).
- R3: One system clock after the block sees the falling sclk_i edge that follows the fifth command bit, track_o is 1.
- R4: At the edge where the block sees the falling sclk_i edge that follows the eighth command bit, track_o falls and hold_o rises. track_o and hold_o are never 1 together.
- R5: Command bit 3 = 1 selects single-ended mode: pos_ch_o = bits 6..4 (the channel), neg_com_o = 1, neg_ch_o = 0.
- R6: Command bit 3 = 0 selects differential mode: neg_com_o = 0, pos_ch_o = channel, and neg_ch_o = channel with bit 0 inverted. The pair is given by channel bits 2..1, and channel bit 0 swaps polarity.
- R7: Command bits 2..0 have no effect on the selects, the timing or the result.
- R8: Driving cs_ni to 1 discards a partly received word. The next word is decoded from its own start bit.
- R9: hold_o stays 1 for exactly 10 system clocks. The first trial code on dac_code_o is 10'h200, and each step keeps its trial bit when cmp_i is 1. done_o pulses for one cycle as hold_o falls, and result_o then holds the final code.
- R10: When hold_o falls, track_o returns to 1 and the selects keep their values.
- R11: Rising sclk_i edges while hold_o is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from host |
| cs_ni | input | 1 | Chip select, active low |
| din_i | input | 1 | Serial command data |
| cmp_i | input | 1 | Comparator: 1 when input >= trial code |
| track_o | output | 1 | Sampling capacitor tracks positive input |
| hold_o | output | 1 | Sample held, conversion running; sampling node on negative input |
| pos_ch_o | output | 3 | Positive input channel |
| neg_ch_o | output | 3 | Negative input channel (differential) |
| neg_com_o | output | 1 | Negative input is the common pin |
| dac_code_o | output | 10 | Trial code for the comparator |
| result_o | output | 10 | Last conversion result |
| done_o | output | 1 | One-cycle pulse when result_o is updated |

## Verification
Serial edges are driven on the falling system clock and are seen at the next rising edge. So track_o is sampled one falling clock after the fifth falling sclk_i edge is driven, and hold_o one falling clock after the eighth. From that first hold sample, the bench counts falling clocks while hold_o stays 1 and expects exactly 10. In the sample that follows, it expects done_o, track_o and result_o, and in the sample after that it expects done_o to be low again. The bench models the comparator as a combinational compare of a chosen 10-bit value against dac_code_o, so every result must equal that value.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  parameter int unsigned CH_W   = 3;
  parameter int unsigned WORD_W = 8;
  parameter int unsigned RES_W  = 10;
  // start bit + channel + mode bit
  localparam int unsigned TRK_BITS = CH_W + 2;

  typedef struct packed {
    logic [CH_W-1:0] ch;
    logic            single;
  } cfg_t;
endpackage

// File: rtl/sadc_word_rx.sv
module sadc_word_rx
  import sadc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic din_i,
  input  logic busy_i,
  output logic trk_evt_o,
  output logic hld_evt_o,
  output cfg_t cfg_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam int unsigned SR_W  = CH_W + 1;

  logic             sclk_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SR_W-1:0]  sr_q;
  logic             rise, fall;

  assign rise = sclk_i & ~sclk_q;
  assign fall = ~sclk_i & sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      sr_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      if (cs_ni) begin
        cnt_q <= '0;
      end else if (rise && !busy_i) begin
        if (cnt_q == '0) begin
          // hunt for start bit
          if (din_i) begin
            cnt_q <= CNT_W'(1);
            sr_q  <= '0;
          end
        end else if (cnt_q < CNT_W'(WORD_W)) begin
          sr_q  <= {sr_q[SR_W-2:0], din_i};
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end else if (fall && cnt_q == CNT_W'(WORD_W)) begin
        cnt_q <= '0;
      end
    end
  end

  assign trk_evt_o = fall & ~cs_ni & (cnt_q == CNT_W'(TRK_BITS));
  assign hld_evt_o = fall & ~cs_ni & (cnt_q == CNT_W'(WORD_W));
  assign cfg_o     = cfg_t'(sr_q);

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(WORD_W));
  assert_no_hold_while_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hld_evt_o |-> !busy_i);
endmodule

// File: rtl/sadc_mux_dec.sv
module sadc_mux_dec
  import sadc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_i,
  input  cfg_t            cfg_i,
  output logic [CH_W-1:0] pos_ch_o,
  output logic [CH_W-1:0] neg_ch_o,
  output logic            neg_com_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_ch_o  <= '0;
      neg_ch_o  <= '0;
      neg_com_o <= 1'b1;
    end else if (ld_i) begin
      pos_ch_o <= cfg_i.ch;
      if (cfg_i.single) begin
        neg_ch_o  <= '0;
        neg_com_o <= 1'b1;
      end else begin
        // partner is the other member of the even/odd pair
        neg_ch_o  <= cfg_i.ch ^ CH_W'(1);
        neg_com_o <= 1'b0;
      end
    end
  end

  assert_diff_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !neg_com_o |-> (pos_ch_o[CH_W-1:1] == neg_ch_o[CH_W-1:1] && pos_ch_o[0] != neg_ch_o[0]));
  assert_single_neg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    neg_com_o |-> neg_ch_o == '0);
endmodule

// File: rtl/sadc_sar.sv
module sadc_sar
  import sadc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_o,
  output logic             busy_o,
  output logic             fin_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  localparam int unsigned STEP_W = $clog2(RES_W);

  logic [STEP_W-1:0] step_q;
  logic [RES_W-1:0]  code_q, mask, keep;

  assign mask  = RES_W'(1) << (STEP_W'(RES_W - 1) - step_q);
  assign keep  = cmp_i ? (code_q | mask) : code_q;
  assign dac_o = busy_o ? (code_q | mask) : result_o;
  assign fin_o = busy_o && step_q == STEP_W'(RES_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= '0;
      code_q   <= '0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        busy_o <= 1'b1;
        step_q <= '0;
        code_q <= '0;
      end else if (busy_o) begin
        code_q <= keep;
        if (fin_o) begin
          busy_o   <= 1'b0;
          done_o   <= 1'b1;
          result_o <= keep;
        end else begin
          step_q <= step_q + STEP_W'(1);
        end
      end
    end
  end

  assert_done_after_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_result_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
endmodule

// File: rtl/sadc_ctrl_fe.sv
module sadc_ctrl_fe
  import sadc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             cs_ni,
  input  logic             din_i,
  input  logic             cmp_i,
  output logic             track_o,
  output logic             hold_o,
  output logic [CH_W-1:0]  pos_ch_o,
  output logic [CH_W-1:0]  neg_ch_o,
  output logic             neg_com_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);
  logic trk_evt, hld_evt, busy, fin;
  cfg_t cfg;

  sadc_word_rx u_rx (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .din_i,
    .busy_i   (busy),
    .trk_evt_o(trk_evt),
    .hld_evt_o(hld_evt),
    .cfg_o    (cfg)
  );

  sadc_mux_dec u_dec (
    .clk_i, .rst_ni,
    .ld_i     (trk_evt),
    .cfg_i    (cfg),
    .pos_ch_o,
    .neg_ch_o,
    .neg_com_o
  );

  sadc_sar u_sar (
    .clk_i, .rst_ni,
    .start_i (hld_evt),
    .cmp_i,
    .dac_o   (dac_code_o),
    .busy_o  (busy),
    .fin_o   (fin),
    .done_o,
    .result_o
  );

  assign hold_o = busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              track_o <= 1'b0;
    else if (hld_evt)         track_o <= 1'b0;
    else if (trk_evt || fin)  track_o <= 1'b1;
  end

  assert_track_hold_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(track_o && hold_o));
  assert_acquire_before_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(track_o));
  assert_resume_track_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> (track_o && done_o));
  assert_sel_stable_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> $stable(pos_ch_o) && $stable(neg_com_o));
endmodule

// File: tb/tb_sadc_ctrl_fe.sv
module tb_sadc_ctrl_fe;
  localparam int H = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic [9:0] analog = '0;
  logic cmp;
  logic track, hold, neg_com, done;
  logic [2:0] pos_ch, neg_ch;
  logic [9:0] dac, result;
  int checks = 0, errors = 0, cyc = 0;
  bit first_word = 1'b1;

  always #2.5 clk = ~clk;
  assign cmp = (analog >= dac);

  sadc_ctrl_fe dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .din_i(din),
    .cmp_i(cmp), .track_o(track), .hold_o(hold), .pos_ch_o(pos_ch),
    .neg_ch_o(neg_ch), .neg_com_o(neg_com), .dac_code_o(dac),
    .result_o(result), .done_o(done)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_neg(input logic [7:0] w);
    return w[3] ? 3'd0 : (w[6:4] ^ 3'd1);
  endfunction

  task automatic clock_bit(input logic b);
    din = b; sclk = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic send_word(input logic [7:0] w, input int lead, input logic [9:0] v,
                           input bit poke, input string tag);
    int n;
    cs_n = 1'b0; analog = v;
    for (int k = 0; k < lead; k++) clock_bit(1'b0);   // R2 skipped zeros
    for (int i = 0; i < 8; i++) begin
      din = w[7-i]; sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
      if (i == 4) begin
        if (first_word) check("R3 track before fifth fall", int'(track), 0);
        @(negedge clk);
        check("R3 track after fifth fall", int'(track), 1);
        repeat (H-1) @(negedge clk);
      end else if (i < 7) begin
        repeat (H) @(negedge clk);
      end
    end
    first_word = 1'b0;
    @(negedge clk);
    check("R4 hold up", int'(hold), 1);
    check("R4 track down", int'(track), 0);
    check("R9 first trial code", int'(dac), 512);
    n = 0;
    while (hold && n < 40) begin
      n++;
      if (poke && n == 2) begin din = 1'b1; sclk = 1'b1; end
      if (poke && n == 6) sclk = 1'b0;
      @(negedge clk);
    end
    check("R9 hold length", n, 10);
    check("R9 done pulse", int'(done), 1);
    check("R9 result", int'(result), int'(v));
    check("R10 track resumes", int'(track), 1);
    check({tag, " pos select"}, int'(pos_ch), int'(w[6:4]));
    check({tag, " neg common"}, int'(neg_com), int'(w[3]));
    check({tag, " neg select"}, int'(neg_ch), int'(exp_neg(w)));
    @(negedge clk);
    check("R9 done single cycle", int'(done), 0);
    check("R9 result held", int'(result), int'(v));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] p0, n0; logic c0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 track", int'(track), 0);
    check("R1 hold", int'(hold), 0);
    check("R1 done", int'(done), 0);
    check("R1 result", int'(result), 0);
    check("R1 pos", int'(pos_ch), 0);
    check("R1 neg", int'(neg_ch), 0);
    check("R1 neg_com", int'(neg_com), 1);

    // R5 single-ended, extremes of value, leading zeros (R2)
    send_word(8'b1_101_1_000, 2, 10'h3FF, 1'b0, "R5");
    send_word(8'b1_000_1_000, 0, 10'h000, 1'b0, "R5");
    // R6 both polarities of a pair
    send_word(8'b1_010_0_000, 1, 10'h155, 1'b0, "R6");
    send_word(8'b1_011_0_000, 0, 10'h2AA, 1'b0, "R6");
    send_word(8'b1_111_0_000, 0, 10'h200, 1'b0, "R6");

    // R7 reserved bits ignored
    send_word(8'b1_110_0_000, 0, 10'h123, 1'b0, "R7");
    p0 = pos_ch; n0 = neg_ch; c0 = neg_com;
    send_word(8'b1_110_0_111, 0, 10'h123, 1'b0, "R7");
    check("R7 pos same", int'(pos_ch), int'(p0));
    check("R7 neg same", int'(neg_ch), int'(n0));
    check("R7 com same", int'(neg_com), int'(c0));

    // R11 serial edge during hold must not start a word
    send_word(8'b1_001_1_010, 0, 10'h0F0, 1'b1, "R11");
    send_word(8'b1_100_0_101, 0, 10'h00F, 1'b0, "R11");

    // R8 abort a partial word
    cs_n = 1'b0;
    clock_bit(1'b1); clock_bit(1'b1); clock_bit(1'b1);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    send_word(8'b1_000_0_000, 0, 10'h081, 1'b0, "R8");

    // random words
    for (int r = 0; r < 30; r++) begin
      logic [7:0] w;
      w = {1'b1, 7'($urandom)};
      send_word(w, int'($urandom % 3), 10'($urandom), 1'b0, w[3] ? "R5" : "R6");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule